// File: doc/BRIEF.md
# SFP Slot Control and Status Unit

This block is the fabric logic for one SFP28 slot in a four-port Ethernet design. Software reaches it through a small register interface with two words. The control word holds the transceiver lane's reset requests and two spare rate-control lines. The status word returns that lane's transmit and receive reset-done flags. The unit places its reset requests on its own bit of the shared 4-bit reset buses and takes its done flags from the same bit of the shared 4-bit done buses. It also turns the done flags into the MAC core and serdes resets.

On the module side, the transmitter-disable pin stays low and the two rate-select pins take a level fixed by the build's line rate. The absence, loss-of-signal and transmit-fault inputs are asynchronous. Each one passes through a two-flop synchroniser. The synchronised absence bit is exported so that it can be placed in a shared presence word. A green/red LED pair shows whether a module is present and whether its link is up.

Top module: `sfp_slot_ctrl`

## Requirements
- R1: While reset is asserted and after it, until the first write, the control word reads 0 and every bit of the three reset request buses is 0.
- R2: A write to offset 0x0 stores wdata[4:0], which reads back at offset 0x0. Bit 0 is the full lane reset, bit 1 the TX datapath reset, bit 2 the RX datapath reset, and bits 3 and 4 drive rate_ctrl[0] and rate_ctrl[1]. All of these take effect on the cycle after the write.
- R3: The three reset request bits drive only bit PORT_IDX of their 4-bit buses. Every other bus bit stays 0.
- R4: A read at offset 0x8 returns bit 0 = TX reset done and bit 1 = RX reset done, taken from bit PORT_IDX of the done buses. The done bits of the other lanes do not affect the value read.
- R5: Writes to offset 0x8 or to any unmapped offset leave the control word unchanged. Reads from unmapped offsets return 0.
- R6: The TX core and TX serdes resets equal the inverse of the lane's TX done bit. The RX core and RX serdes resets equal the inverse of the lane's RX done bit.
- R7: The module transmitter-disable output is always low.
- R8: Both rate-select outputs are low when LINE_25G is 0 and high when LINE_25G is 1.
- R9: With the synchronised absence bit high, both LEDs are off. With a module present, green is on and red off when link_up is 1, and red is on and green off when link_up is 0.
- R10: The absence, loss-of-signal and transmit-fault inputs reach their synchronised outputs after exactly two clock edges. During reset, absence reads 1 and the other two read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| gt_rst_all_bus | output | 4 | Shared full lane reset request bus |
| gt_rst_tx_bus | output | 4 | Shared TX datapath reset request bus |
| gt_rst_rx_bus | output | 4 | Shared RX datapath reset request bus |
| rate_ctrl | output | 2 | Spare rate-control lines from control bits 3 and 4 |
| gt_tx_done_bus | input | 4 | Shared TX reset-done bus |
| gt_rx_done_bus | input | 4 | Shared RX reset-done bus |
| tx_core_rst | output | 1 | MAC TX core reset |
| tx_serdes_rst | output | 1 | MAC TX serdes reset |
| rx_core_rst | output | 1 | MAC RX core reset |
| rx_serdes_rst | output | 1 | MAC RX serdes reset |
| link_up | input | 1 | MAC receive link status for this port |
| mod_absent_in | input | 1 | Module absence pin, active high, asynchronous |
| rx_los_in | input | 1 | Module loss-of-signal pin, asynchronous |
| tx_fault_in | input | 1 | Module transmit-fault pin, asynchronous |
| mod_absent_sync | output | 1 | Synchronised absence bit, for the shared presence word |
| rx_los_sync | output | 1 | Synchronised loss-of-signal |
| tx_fault_sync | output | 1 | Synchronised transmit fault |
| sfp_tx_disable | output | 1 | Module transmitter disable |
| sfp_rate_sel | output | 2 | Module rate-select pins |
| led_green | output | 1 | Green status LED |
| led_red | output | 1 | Red status LED |

## Verification
The hardest property to show from the ports is lane isolation. A design that fans a request out to every lane can still pass a check that looks only at the port's own lane bit. A status read that picks the wrong done bit can still pass if all lanes report the same value. The bench therefore runs the unit as port 2 and drives the done buses so that lane 2 differs from every other lane. It then compares whole 4-bit buses against a one-hot mask.

The synchroniser depth is checked by sampling after one edge and again after two. A missing stage or an extra stage therefore shows up.

// File: rtl/sfp_slot_pkg.sv
// Shared constants and types for the SFP slot control unit.
// Assumes byte offsets on a 4-bit register address.
package sfp_slot_pkg;
    localparam int CTRL_BITS = 5;
    localparam int STAT_BITS = 2;
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h8;

    // Control word layout; bit 0 is the full lane reset
    typedef struct packed {
        logic [1:0] rate;
        logic       rst_rx;
        logic       rst_tx;
        logic       rst_all;
    } gt_ctrl_t;

    typedef enum logic [1:0] {
        LED_DARK      = 2'd0,
        LED_LINK_UP   = 2'd1,
        LED_LINK_DOWN = 2'd2
    } led_state_e;
endpackage

// File: rtl/sfp_bit_sync.sv
// Multi-bit, per-bit independent flop-chain synchroniser.
// Assumes each bit is an unrelated level signal; no bus coherence implied.
module sfp_bit_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage toward the output
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= async_in;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sfp_regfile.sv
// Control/status register pair. Control word is read/write at OFS_CTRL,
// status word read-only at OFS_STAT. Assumes single-cycle write strobes.
module sfp_regfile
    import sfp_slot_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_done,
    input  logic              rx_done,
    output gt_ctrl_t          ctrl,
    output logic [DATA_W-1:0] rdata
);
    gt_ctrl_t ctrl_q;

    // Capture the control word on writes to its own offset only
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr && addr == ADDR_W'(OFS_CTRL)) ctrl_q <= gt_ctrl_t'(wdata[CTRL_BITS-1:0]);
    end

    // Decode the read word from the offset
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) rdata[CTRL_BITS-1:0] = ctrl_q;
        else if (addr == ADDR_W'(OFS_STAT)) rdata[STAT_BITS-1:0] = {rx_done, tx_done};
    end

    assign ctrl = ctrl_q;

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(OFS_CTRL)) |=> (ctrl == gt_ctrl_t'($past(wdata[CTRL_BITS-1:0]))));
    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && addr == ADDR_W'(OFS_CTRL))) |=> $stable(ctrl));
endmodule

// File: rtl/sfp_lane_map.sv
// Places this port's reset requests on its own bit of the shared buses and
// picks its done bits back out. Assumes LANE < NUM_LANES.
module sfp_lane_map
    import sfp_slot_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE      = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  gt_ctrl_t             ctrl,
    input  logic [NUM_LANES-1:0] tx_done_bus,
    input  logic [NUM_LANES-1:0] rx_done_bus,
    output logic [NUM_LANES-1:0] rst_all_bus,
    output logic [NUM_LANES-1:0] rst_tx_bus,
    output logic [NUM_LANES-1:0] rst_rx_bus,
    output logic [1:0]           rate_ctrl,
    output logic                 tx_done,
    output logic                 rx_done
);
    localparam logic [NUM_LANES-1:0] OTHER_MASK = ~(NUM_LANES'(1) << LANE);

    genvar i;
    generate
        for (i = 0; i < NUM_LANES; i++) begin : g_lane
            if (i == LANE) begin : g_own
                assign rst_all_bus[i] = ctrl.rst_all;
                assign rst_tx_bus[i]  = ctrl.rst_tx;
                assign rst_rx_bus[i]  = ctrl.rst_rx;
            end else begin : g_other
                assign rst_all_bus[i] = 1'b0;
                assign rst_tx_bus[i]  = 1'b0;
                assign rst_rx_bus[i]  = 1'b0;
            end
        end
    endgenerate

    assign rate_ctrl = ctrl.rate;
    assign tx_done   = tx_done_bus[LANE];
    assign rx_done   = rx_done_bus[LANE];

    // R3
    lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_all_bus | rst_tx_bus | rst_rx_bus) & OTHER_MASK) == '0);
    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |-> (rst_all_bus == '0 && rst_tx_bus == '0 && rst_rx_bus == '0));
endmodule

// File: rtl/sfp_sideband.sv
// Module sideband: synchronises the module status pins, drives fixed
// disable/rate levels and the LED pair. Assumes link_up is already in clk domain.
module sfp_sideband
    import sfp_slot_pkg::*;
#(
    parameter bit LINE_25G    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       absent_raw,
    input  logic       los_raw,
    input  logic       fault_raw,
    input  logic       link_up,
    output logic       absent_sync,
    output logic       los_sync,
    output logic       fault_sync,
    output logic       tx_disable,
    output logic [1:0] rate_sel,
    output logic       led_green,
    output logic       led_red
);
    localparam logic [2:0] SYNC_RST = 3'b001;

    logic [2:0] synced;
    led_state_e led_st;
    logic [1:0] age_q;

    sfp_bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({fault_raw, los_raw, absent_raw}),
        .sync_out (synced)
    );

    assign absent_sync = synced[0];
    assign los_sync    = synced[1];
    assign fault_sync  = synced[2];
    assign tx_disable  = 1'b0;
    assign rate_sel    = {2{LINE_25G}};

    // Pick the LED state from presence and link
    always_comb begin
        if (absent_sync)  led_st = LED_DARK;
        else if (link_up) led_st = LED_LINK_UP;
        else              led_st = LED_LINK_DOWN;
    end

    assign led_green = (led_st == LED_LINK_UP);
    assign led_red   = (led_st == LED_LINK_DOWN);

    // Count cycles since reset so latency checks never look before it
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R9
    led_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({led_green, led_red}));
    // R9
    led_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        absent_sync |-> (!led_green && !led_red));
    // R10
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_STAGES == 2 && age_q >= 2'd2) |->
        ({fault_sync, los_sync, absent_sync} == $past({fault_raw, los_raw, absent_raw}, 2)));
endmodule

// File: rtl/sfp_slot_ctrl.sv
// Top of the per-slot control unit: register pair, lane mapping, MAC reset
// derivation and module sideband. Assumes one instance per slot, PORT_IDX distinct.
module sfp_slot_ctrl
    import sfp_slot_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int PORT_IDX    = 0,
    parameter bit LINE_25G    = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_LANES-1:0] gt_rst_all_bus,
    output logic [NUM_LANES-1:0] gt_rst_tx_bus,
    output logic [NUM_LANES-1:0] gt_rst_rx_bus,
    output logic [1:0]           rate_ctrl,
    input  logic [NUM_LANES-1:0] gt_tx_done_bus,
    input  logic [NUM_LANES-1:0] gt_rx_done_bus,
    output logic                 tx_core_rst,
    output logic                 tx_serdes_rst,
    output logic                 rx_core_rst,
    output logic                 rx_serdes_rst,
    input  logic                 link_up,
    input  logic                 mod_absent_in,
    input  logic                 rx_los_in,
    input  logic                 tx_fault_in,
    output logic                 mod_absent_sync,
    output logic                 rx_los_sync,
    output logic                 tx_fault_sync,
    output logic                 sfp_tx_disable,
    output logic [1:0]           sfp_rate_sel,
    output logic                 led_green,
    output logic                 led_red
);
    gt_ctrl_t ctrl;
    logic     tx_done;
    logic     rx_done;

    sfp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .tx_done (tx_done),
        .rx_done (rx_done),
        .ctrl    (ctrl),
        .rdata   (reg_rdata)
    );

    sfp_lane_map #(.NUM_LANES(NUM_LANES), .LANE(PORT_IDX)) u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .tx_done_bus (gt_tx_done_bus),
        .rx_done_bus (gt_rx_done_bus),
        .rst_all_bus (gt_rst_all_bus),
        .rst_tx_bus  (gt_rst_tx_bus),
        .rst_rx_bus  (gt_rst_rx_bus),
        .rate_ctrl   (rate_ctrl),
        .tx_done     (tx_done),
        .rx_done     (rx_done)
    );

    // MAC resets are held while the lane reports not done
    assign tx_core_rst   = ~tx_done;
    assign tx_serdes_rst = ~tx_done;
    assign rx_core_rst   = ~rx_done;
    assign rx_serdes_rst = ~rx_done;

    sfp_sideband #(.LINE_25G(LINE_25G), .SYNC_STAGES(SYNC_STAGES)) u_side (
        .clk         (clk),
        .rst_n       (rst_n),
        .absent_raw  (mod_absent_in),
        .los_raw     (rx_los_in),
        .fault_raw   (tx_fault_in),
        .link_up     (link_up),
        .absent_sync (mod_absent_sync),
        .los_sync    (rx_los_sync),
        .fault_sync  (tx_fault_sync),
        .tx_disable  (sfp_tx_disable),
        .rate_sel    (sfp_rate_sel),
        .led_green   (led_green),
        .led_red     (led_red)
    );

    // R6
    mac_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_core_rst == tx_serdes_rst) && (rx_core_rst == rx_serdes_rst)
        && (tx_core_rst != gt_tx_done_bus[PORT_IDX]) && (rx_core_rst != gt_rx_done_bus[PORT_IDX]));
endmodule

// File: tb/sfp_slot_ctrl_bench.sv
module sfp_slot_ctrl_bench;
    localparam int PORT = 2;
    localparam bit HI   = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  rst_all, rst_tx, rst_rx;
    logic [1:0]  rate_ctrl;
    logic [3:0]  tx_done_bus = '0, rx_done_bus = '0;
    logic        tx_core_rst, tx_serdes_rst, rx_core_rst, rx_serdes_rst;
    logic        link_up = 1'b0, mod_abs = 1'b1, los = 1'b0, fault = 1'b0;
    logic        abs_s, los_s, fault_s, tx_dis, led_g, led_r;
    logic [1:0]  rate_sel;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sfp_slot_ctrl #(.PORT_IDX(PORT), .LINE_25G(HI)) u_sfp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gt_rst_all_bus(rst_all), .gt_rst_tx_bus(rst_tx), .gt_rst_rx_bus(rst_rx),
        .rate_ctrl(rate_ctrl), .gt_tx_done_bus(tx_done_bus), .gt_rx_done_bus(rx_done_bus),
        .tx_core_rst(tx_core_rst), .tx_serdes_rst(tx_serdes_rst),
        .rx_core_rst(rx_core_rst), .rx_serdes_rst(rx_serdes_rst),
        .link_up(link_up), .mod_absent_in(mod_abs), .rx_los_in(los), .tx_fault_in(fault),
        .mod_absent_sync(abs_s), .rx_los_sync(los_s), .tx_fault_sync(fault_s),
        .sfp_tx_disable(tx_dis), .sfp_rate_sel(rate_sel), .led_green(led_g), .led_red(led_r)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        read_reg(4'h0, v);
        check("R1 ctrl during reset", v, 32'h0);
        check("R1 buses during reset", {rst_all, rst_tx, rst_rx}, 32'h0);
        check("R10 sync reset values", {abs_s, los_s, fault_s}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(4'h0, v);
        check("R1 ctrl after reset", v, 32'h0);
    endtask

    task automatic t_ctrl_write;
        logic [31:0] v;
        write_reg(4'h0, 32'hFFFF_FFFF);
        read_reg(4'h0, v);
        check("R2 ctrl readback all ones", v, 32'h1F);
        check("R2 rate_ctrl from bits 3-4", rate_ctrl, 32'h3);
        write_reg(4'h0, 32'h0000_0012);
        read_reg(4'h0, v);
        check("R2 ctrl readback 0x12", v, 32'h12);
        check("R2 rate_ctrl bit4 only", rate_ctrl, 32'h2);
        check("R2 tx bus from bit1", rst_tx, 32'h4);
        check("R2 all/rx clear", {rst_all, rst_rx}, 32'h0);
    endtask

    task automatic t_lane_isolation;
        write_reg(4'h0, 32'h0000_0007);
        check("R3 all bus one-hot lane", rst_all, 32'h4);
        check("R3 tx bus one-hot lane", rst_tx, 32'h4);
        check("R3 rx bus one-hot lane", rst_rx, 32'h4);
        write_reg(4'h0, 32'h0000_0005);
        check("R3 rx only lane bit", rst_rx, 32'h4);
        check("R3 tx cleared", rst_tx, 32'h0);
    endtask

    task automatic t_status_read;
        logic [31:0] v;
        @(negedge clk);
        tx_done_bus = 4'b1011; rx_done_bus = 4'b0100;
        read_reg(4'h8, v);
        check("R4 status lane bits differ from others", v, 32'h2);
        tx_done_bus = 4'b0100; rx_done_bus = 4'b1011;
        read_reg(4'h8, v);
        check("R4 status swapped", v, 32'h1);
    endtask

    task automatic t_mac_resets;
        @(negedge clk);
        tx_done_bus = 4'b1011; rx_done_bus = 4'b0100;
        #1;
        check("R6 resets tx held rx released",
              {tx_core_rst, tx_serdes_rst, rx_core_rst, rx_serdes_rst}, 32'hC);
        tx_done_bus = 4'b0100; rx_done_bus = 4'b1011;
        #1;
        check("R6 resets rx held tx released",
              {tx_core_rst, tx_serdes_rst, rx_core_rst, rx_serdes_rst}, 32'h3);
    endtask

    task automatic t_ignored_access;
        logic [31:0] v;
        write_reg(4'h0, 32'h0000_000B);
        write_reg(4'h8, 32'hFFFF_FFFF);
        read_reg(4'h0, v);
        check("R5 status write ignored", v, 32'hB);
        write_reg(4'h4, 32'h0000_0000);
        read_reg(4'h0, v);
        check("R5 unmapped write ignored", v, 32'hB);
        read_reg(4'h4, v);
        check("R5 unmapped read zero", v, 32'h0);
    endtask

    task automatic t_sideband_pins;
        check("R7 tx disable low", tx_dis, 32'h0);
        check("R8 rate select high in 25G build", rate_sel, 32'h3);
    endtask

    task automatic t_sync_latency;
        @(negedge clk);
        mod_abs = 1'b0; los = 1'b1; fault = 1'b1;
        @(negedge clk);
        check("R10 not yet after one edge", {abs_s, los_s, fault_s}, 32'h4);
        @(negedge clk);
        check("R10 visible after two edges", {abs_s, los_s, fault_s}, 32'h3);
        los = 1'b0; fault = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 los/fault cleared", {los_s, fault_s}, 32'h0);
    endtask

    task automatic t_leds;
        @(negedge clk);
        link_up = 1'b1;
        #1 check("R9 present link up green", {led_g, led_r}, 32'h2);
        link_up = 1'b0;
        #1 check("R9 present link down red", {led_g, led_r}, 32'h1);
        @(negedge clk);
        mod_abs = 1'b1; link_up = 1'b1;
        @(negedge clk);
        check("R9 absence not yet synced", {led_g, led_r}, 32'h2);
        @(negedge clk);
        check("R9 absent both off", {led_g, led_r}, 32'h0);
        check("R10 exported absence", abs_s, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ctrl_write();
        t_lane_isolation();
        t_status_read();
        t_mac_resets();
        t_ignored_access();
        t_sideband_pins();
        t_sync_latency();
        t_leds();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule